// File: doc/BRIEF.md
# Column Power-Pulsing Sequencer

This controller steps the analog front-ends of a pixel array between a full-power and a low-power state, one column per step, so that the supply current of the array rises and falls in small increments instead of in one jump. A programmable gap, counted in clock cycles, separates successive column changes. Once acquisition has finished, the array can be brought down to low power. It is brought back up before the next acquisition.

The sequencer holds one enable bit per column. A power-up request walks the enables on from column 0 toward the highest column. A power-down request walks them off from the highest column toward column 0. While a walk is in progress the block reports busy and ignores every request. When the last column has switched, it raises a one-cycle done pulse. The analog switches driven by the enable vector are outside this block.

Top module: `col_power_sequencer`

## Requirements
- R1: After reset, every bit of `col_en` is 0 (all columns low power), and `busy` and `done` are 0.
- R2: A `pwr_up_req` sampled high with all columns off (after reset or after a completed power-down) sets `col_en[0]` at that same clock edge. Further columns are then set in ascending index order until all 64 are set. Throughout, the set bits of `col_en` form one contiguous run that starts at bit 0.
- R3: A `pwr_dn_req` sampled high with all columns on clears `col_en[63]` at that same clock edge. Further columns are then cleared in descending index order until none is set.
- R4: No clock edge changes more than one bit of `col_en`.
- R5: With gap value g, successive column changes lie exactly g+1 cycles apart; g = 0 gives one column per cycle. The final column of a walk therefore changes 63·(g+1) cycles after the first.
- R6: The gap value is captured on the edge that accepts a request. Changes to `gap_cycles` during a walk have no effect on its timing.
- R7: `busy` is 1 from the edge that accepts a request until the edge that switches the final column, and 0 at all other times.
- R8: `done` is 1 for exactly the one cycle that follows the edge switching the final column of a walk, and 0 otherwise.
- R9: Requests of either kind that arrive during a walk are discarded and not remembered. The walk finishes unchanged, and afterwards the vector stays where the walk left it.
- R10: `pwr_up_req` while all columns are on, and `pwr_dn_req` while all columns are off, leave `col_en` unchanged and `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_up_req | input | 1 | Request to power the array up |
| pwr_dn_req | input | 1 | Request to put the array in low power |
| gap_cycles | input | GAP_W (8) | Extra cycles between successive column changes |
| col_en | output | NCOLS (64) | Per-column full-power enable, bit i = column i |
| busy | output | 1 | A column walk is in progress |
| done | output | 1 | One-cycle pulse when a walk completes |

## Verification
If a request is accepted at edge E, column k of the walk has switched by the edge E + k·(g+1). `busy` falls, and `done` rises, on the edge E + 63·(g+1). `done` falls again one edge later. The bench drives inputs on the falling edge and samples all outputs on the following falling edge, which places each sample half a period after the edge whose result it checks. On every cycle of a walk, the bench compares the enable count it expects from the formula above against the outputs. It also checks the cycle after completion, and holds ignored requests for several cycles while confirming that nothing moves.

// File: rtl/pps_pkg.sv
// Package: shared types for the column power-pulsing sequencer.
// Assumes: nothing beyond the standard language.
package pps_pkg;

    // Sequencer states; the two ramp states are the busy ones.
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_RAMP_UP   = 3'd1,
        ST_ON        = 3'd2,
        ST_RAMP_DOWN = 3'd3,
        ST_OFF       = 3'd4
    } seq_state_t;

endpackage

// File: rtl/pps_gap_timer.sv
// Module: pps_gap_timer
// Emits a one-cycle step strobe every (gap+1) cycles while run is high.
// The gap is captured on load, so later changes at gap_in do not affect the walk.
// Assumes: load and run are never high in the same cycle.
module pps_gap_timer #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [GAP_W-1:0] gap_in,
    output logic             step
);

    logic [GAP_W-1:0] gap_q;
    logic [GAP_W-1:0] cnt_q;

    // Capture the gap at start and count it down between steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            gap_q <= gap_in;
            cnt_q <= gap_in;
        end else if (run) begin
            if (cnt_q == '0) cnt_q <= gap_q;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    // A step falls due when the countdown has reached zero.
    assign step = run && (cnt_q == '0);

endmodule

// File: rtl/pps_col_pointer.sv
// Module: pps_col_pointer
// Holds the per-column enable flops and the index of the next column to switch.
// A start switches the first column of the walk at once; each step switches the next one.
// Assumes: NCOLS >= 2, and start_up, start_dn and step are mutually exclusive.
module pps_col_pointer #(
    parameter int NCOLS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_up,
    input  logic             start_dn,
    input  logic             step,
    input  logic             dir_up,
    output logic [NCOLS-1:0] col_en,
    output logic             at_last
);

    localparam int            IW      = (NCOLS > 2) ? $clog2(NCOLS) : 1;
    localparam logic [IW-1:0] TOP_IDX = IW'(NCOLS - 1);

    logic [IW-1:0] idx_q;

    // Track the next column to switch in the current walk direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (start_up) begin
            idx_q <= IW'(1);
        end else if (start_dn) begin
            idx_q <= TOP_IDX - 1'b1;
        end else if (step) begin
            if (dir_up) idx_q <= idx_q + 1'b1;
            else        idx_q <= idx_q - 1'b1;
        end
    end

    // The column under the index is the final one of the walk.
    assign at_last = dir_up ? (idx_q == TOP_IDX) : (idx_q == '0);

    // One enable flop per column; only the indexed column may change on a step.
    for (genvar i = 0; i < NCOLS; i++) begin : g_col
        localparam bit IS_FIRST = (i == 0);
        localparam bit IS_LAST  = (i == NCOLS - 1);
        logic hit;
        assign hit = step && (idx_q == IW'(i));

        // Set, clear or hold this column's enable.
        always_ff @(posedge clk) begin
            if (!rst_n)                    col_en[i] <= 1'b0;
            else if (IS_FIRST && start_up) col_en[i] <= 1'b1;
            else if (IS_LAST && start_dn)  col_en[i] <= 1'b0;
            else if (hit)                  col_en[i] <= dir_up;
        end
    end

endmodule

// File: rtl/pps_seq_fsm.sv
// Module: pps_seq_fsm
// Top-level sequencing: accepts requests only in a settled state and tracks
// the walk direction. Raises done for one cycle when the final column switches.
// Assumes: step and at_last come from the timer and the pointer of the same walk.
module pps_seq_fsm
    import pps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       up_req,
    input  logic       dn_req,
    input  logic       step,
    input  logic       at_last,
    output logic       start_up,
    output logic       start_dn,
    output logic       dir_up,
    output logic       busy,
    output logic       done
);

    seq_state_t state_q, state_d;
    logic       finish;
    logic       done_q;

    assign finish   = step && at_last;
    assign start_up = ((state_q == ST_IDLE) || (state_q == ST_OFF)) && up_req;
    assign start_dn = (state_q == ST_ON) && dn_req;
    assign dir_up   = (state_q == ST_RAMP_UP);
    assign busy     = (state_q == ST_RAMP_UP) || (state_q == ST_RAMP_DOWN);
    assign done     = done_q;

    // Choose the next state from requests and walk completion.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE, ST_OFF: if (up_req) state_d = ST_RAMP_UP;
            ST_ON:           if (dn_req) state_d = ST_RAMP_DOWN;
            ST_RAMP_UP:      if (finish) state_d = ST_ON;
            ST_RAMP_DOWN:    if (finish) state_d = ST_OFF;
            default:         state_d = ST_IDLE;
        endcase
    end

    // Register the state and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= finish;
        end
    end

endmodule

// File: rtl/col_power_sequencer.sv
// Module: col_power_sequencer
// Walks per-column power enables up from column 0 or down from the top column,
// with a programmable gap of gap_cycles extra cycles between column changes.
// Assumes: a synchronous active-low reset; requests are level-sampled on each edge.
module col_power_sequencer #(
    parameter int NCOLS = 64,
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_up_req,
    input  logic             pwr_dn_req,
    input  logic [GAP_W-1:0] gap_cycles,
    output logic [NCOLS-1:0] col_en,
    output logic             busy,
    output logic             done
);

    logic start_up, start_dn, step, at_last, dir_up;

    pps_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_req   (pwr_up_req),
        .dn_req   (pwr_dn_req),
        .step     (step),
        .at_last  (at_last),
        .start_up (start_up),
        .start_dn (start_dn),
        .dir_up   (dir_up),
        .busy     (busy),
        .done     (done)
    );

    pps_gap_timer #(.GAP_W(GAP_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start_up || start_dn),
        .run    (busy),
        .gap_in (gap_cycles),
        .step   (step)
    );

    pps_col_pointer #(.NCOLS(NCOLS)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_up (start_up),
        .start_dn (start_dn),
        .step     (step),
        .dir_up   (dir_up),
        .col_en   (col_en),
        .at_last  (at_last)
    );

endmodule

// File: rtl/col_power_sequencer_chk.sv
// Module: col_power_sequencer_chk
// Port-level properties of the sequencer, attached to the top module by bind.
// Assumes: the same parameters as the bound instance.
module col_power_sequencer_chk #(
    parameter int NCOLS = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_up_req,
    input logic             pwr_dn_req,
    input logic [NCOLS-1:0] col_en,
    input logic             busy,
    input logic             done
);

    localparam logic [NCOLS-1:0] ONE = {{(NCOLS-1){1'b0}}, 1'b1};

    logic [NCOLS-1:0] en_plus1;
    assign en_plus1 = col_en + ONE;

    // R4: at most one column changes per edge.
    p_one_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(col_en ^ $past(col_en)) <= 1);

    // R2 / R3: enables always form a run anchored at column 0.
    p_contig_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_plus1 & col_en) == '0);

    // R7: the edge that raises busy also switches a column.
    p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (col_en != $past(col_en)));

    // R8: done follows a busy cycle and lasts one cycle.
    p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: an all-on array ignores anything but a power-down request.
    p_hold_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (&col_en) && !pwr_dn_req) |=> ((&col_en) && !busy));

    // R10: an all-off array ignores anything but a power-up request.
    p_hold_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (col_en == '0) && !pwr_up_req) |=> ((col_en == '0) && !busy));

endmodule

bind col_power_sequencer col_power_sequencer_chk #(.NCOLS(NCOLS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_up_req (pwr_up_req),
    .pwr_dn_req (pwr_dn_req),
    .col_en     (col_en),
    .busy       (busy),
    .done       (done)
);

// File: tb/col_power_sequencer_test.sv
// Bench: directed scenarios, one task each; inputs change and outputs are sampled on falling edges.
module col_power_sequencer_test;

    localparam int NC = 64;
    localparam int GW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pwr_up_req = 1'b0;
    logic          pwr_dn_req = 1'b0;
    logic [GW-1:0] gap_cycles = '0;
    logic [NC-1:0] col_en;
    logic          busy;
    logic          done;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    col_power_sequencer #(.NCOLS(NC), .GAP_W(GW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_up_req (pwr_up_req),
        .pwr_dn_req (pwr_dn_req),
        .gap_cycles (gap_cycles),
        .col_en     (col_en),
        .busy       (busy),
        .done       (done)
    );

    // Mask with the n lowest columns enabled.
    function automatic logic [NC-1:0] low_mask(input int n);
        if (n <= 0)  return '0;
        if (n >= NC) return '1;
        return {NC{1'b1}} >> (NC - n);
    endfunction

    task automatic check(input bit ok, input string req, input logic [NC-1:0] act,
                         input logic [NC-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R1: state straight after reset.
    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(col_en == '0, "R1 col_en", col_en, '0);
        check(busy == 1'b0, "R1 busy", NC'(busy), '0);
        check(done == 1'b0, "R1 done", NC'(done), '0);
    endtask

    // R10: hold a request that must be ignored and confirm nothing moves.
    task automatic t_ignored(input bit up, input logic [NC-1:0] exp_vec);
        pwr_up_req = up;
        pwr_dn_req = !up;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            check(col_en == exp_vec, "R10 col_en", col_en, exp_vec);
            check(busy == 1'b0, "R10 busy", NC'(busy), '0);
        end
        pwr_up_req = 1'b0;
        pwr_dn_req = 1'b0;
        @(negedge clk);
        check(col_en == exp_vec, "R10 settle", col_en, exp_vec);
    endtask

    // R2/R3/R5/R7/R8 plus, when poke is set, R6 and R9: a full walk checked every cycle.
    task automatic t_walk(input bit up, input int g, input bit poke);
        int last_t;
        int k;
        logic [NC-1:0] exp_vec;
        string tag;
        last_t = (NC - 1) * (g + 1);
        tag = up ? "R2/R5" : "R3/R5";
        gap_cycles = GW'(g);
        pwr_up_req = up;
        pwr_dn_req = !up;
        for (int t = 0; t <= last_t; t++) begin
            @(negedge clk);
            pwr_up_req = 1'b0;
            pwr_dn_req = 1'b0;
            k = t / (g + 1);
            exp_vec = up ? low_mask(k + 1) : low_mask(NC - 1 - k);
            check(col_en == exp_vec, poke ? {tag, "/R6/R9 col_en"} : {tag, " col_en"},
                  col_en, exp_vec);
            check(busy == (t < last_t), "R7 busy", NC'(busy), NC'(t < last_t));
            check(done == (t == last_t), "R8 done", NC'(done), NC'(t == last_t));
            if (poke && t < last_t) begin
                gap_cycles = (g == 0) ? GW'(5) : GW'(0);
                if (t == 10 || t == 11) begin
                    pwr_up_req = 1'b1;
                    pwr_dn_req = 1'b1;
                end
            end
        end
        gap_cycles = GW'(g);
        exp_vec = up ? '1 : '0;
        @(negedge clk);
        check(done == 1'b0, "R8 done falls", NC'(done), '0);
        check(busy == 1'b0, "R9 stays idle", NC'(busy), '0);
        check(col_en == exp_vec, "R9 vector kept", col_en, exp_vec);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        t_reset();
        t_ignored(1'b0, '0);        // power-down while already off
        t_walk(1'b1, 0, 1'b0);      // one column per cycle
        t_ignored(1'b1, '1);        // power-up while already on
        t_walk(1'b0, 2, 1'b1);      // down with gap 2, disturbed mid-walk
        t_ignored(1'b0, '0);
        t_walk(1'b1, 3, 1'b1);      // up again from the off state
        t_walk(1'b0, 0, 1'b0);
        finished = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule